// File: doc/BRIEF.md
# Timer/Counter with Match and Capture

This block is a general purpose up-counter for a peripheral subsystem. Its count register advances either on a prescaled version of the system clock (timer mode) or on selected edges of an external count input (counter mode). Four compare registers watch the count. Each has its own action: carry on, restart the count from zero, or halt it. Each can also raise an interrupt. Every compare hit emits a one-cycle DMA request on its own line.

Two capture channels watch external inputs. On the edge chosen for each channel, the channel copies the live count. All inputs from outside the clock domain pass through a two-flop synchronizer before edge detection.

A host programs the block through a flat word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the read address. Interrupt sources are sticky flags, cleared by writing ones. The single interrupt output is the OR of the flags whose sources are enabled.

Top module: `mtc_timer`

## Requirements
- R1: After synchronous reset every register reads zero, `irq` is low and `dma_req` is all zero.
- R2: In timer mode the prescale count rises by one per clock from 0 up to the prescale value P and then returns to 0. The main count rises by one on each such return, so P=0 advances the count every clock. With the run bit clear, both counts hold.
- R3: The control word at address 0 has these fields: bit0 run, bit1 counter mode, bits3:2 count-edge select, bit4 hold. While hold is set, the main count and the prescale count are forced to zero and no increment occurs. The edge select codes are 0 none, 1 rising, 2 falling, 3 both.
- R4: In counter mode the main count rises by one per selected edge of `cnt_in`, seen after the synchronizer, and the prescale count stays at zero.
- R5: A match i occurs on an increment cycle whose current count equals compare register i. It sets flag bit i and drives `dma_req[i]` high for exactly the following cycle.
- R6: A match whose reset action is set loads zero instead of incrementing, so the count cycles through 0..M and the match repeats every M+1 increments.
- R7: A match whose stop action is set clears the run bit. Without the reset action the count halts at the match value. With both actions the count becomes zero and halts. A host write to the control word in the same cycle takes precedence over the stop.
- R8: Capture channel j copies the main count on its selected edge of `cap_in[j]` and sets flag bit 4+j. Edges that are not selected leave the capture register and the flag untouched.
- R9: Writing 1 to a bit of the flag word at address 12 clears it, and writing 0 leaves it. When a flag is set by an event in the same cycle as it is cleared, the set wins.
- R10: `irq` is high exactly when some flag is set whose source has its interrupt enable set. Flags of sources with the enable clear do not drive `irq`.
- R11: The register map is as follows.
  - 1: prescale value.
  - 2: main count (read only).
  - 3: prescale count (read only).
  - 4..7: compare registers.
  - 8: match actions, three bits per match at bit 3i: irq enable, reset, stop.
  - 9: capture setup, three bits per channel at bit 3j: edge code in bits 1:0, irq enable in bit 2.
  - 10, 11: capture values.
  - 12: flags.

  Writable registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr` |
| cnt_in | input | 1 | External count input, asynchronous |
| cap_in | input | 2 | Capture inputs, asynchronous |
| irq | output | 1 | Combined interrupt |
| dma_req | output | 4 | One-cycle request per compare match |

## Verification
The interesting collision is a capture event setting its flag in the same clock edge as the host writes a 1 to clear that very flag. The bench provokes it by raising a capture input on a known falling edge. It counts the two synchronizer stages and the edge register so that the flag-clear write lands on the exact edge where the capture fires. It then judges by reading the flag word, which must still show the bit set. A follow-up clear with no event pending must then remove it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    // control word, bit0 = run ... bit4 = hold
    typedef struct packed {
        logic      hold;
        edge_sel_e cnt_edge;
        logic      cnt_mode;
        logic      run;
    } ctrl_t;

    typedef struct packed {
        logic stop;
        logic clr;
        logic irq_en;
    } match_act_t;

    typedef struct packed {
        logic      irq_en;
        edge_sel_e sel;
    } cap_cfg_t;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int MACT_BITS = $bits(match_act_t);
    localparam int CCFG_BITS = $bits(cap_cfg_t);

    localparam int A_CTRL    = 0;
    localparam int A_PRESC   = 1;
    localparam int A_TC      = 2;
    localparam int A_PC      = 3;
    localparam int A_MR_BASE = 4;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
        case (sel)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return ~cur & prev;
            EDGE_BOTH: return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
    import tmr_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  edge_sel_e sel,
    output logic      hit
);
    logic [SYNC-1:0] sh;
    logic            prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[SYNC-2:0], din};
            prev <= sh[SYNC-1];
        end
    end

    assign hit = edge_hit(sel, sh[SYNC-1], prev);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         tick
);
    assign tick = en && (count >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)  count <= '0;
        else if (tick)   count <= '0;
        else if (en)     count <= count + 1'b1;
    end

    // R2: the prescale count either wraps to zero or steps by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> (count == '0 || count == W'($past(count) + 1'b1)));

    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(count));

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hit,
    input  logic [W-1:0] tc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (hit) value <= tc;
    end

    // R8: a capture holds the count present on the edge cycle
    assert_cap_copy_R8: assert property (@(posedge clk) disable iff (rst)
        hit |=> value == $past(tc));

    assert_cap_keep_R8: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(value));

endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
    import tmr_pkg::*;
#(
    parameter int W       = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 2,
    parameter int SYNC    = 2,
    parameter int AW      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [W-1:0]       wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [W-1:0]       rd_data,
    input  logic               cnt_in,
    input  logic [N_CAP-1:0]   cap_in,
    output logic               irq,
    output logic [N_MATCH-1:0] dma_req
);
    localparam int NFLAG    = N_MATCH + N_CAP;
    localparam int MACT_W   = MACT_BITS * N_MATCH;
    localparam int CCFG_W   = CCFG_BITS * N_CAP;
    localparam int A_MACT   = A_MR_BASE + N_MATCH;
    localparam int A_CCFG   = A_MACT + 1;
    localparam int A_CAP    = A_CCFG + 1;
    localparam int A_FLAGS  = A_CAP + N_CAP;

    ctrl_t                     ctrl_q;
    logic [W-1:0]              presc_q;
    logic [W-1:0]              tc_q;
    logic [W-1:0]              pc;
    logic [W-1:0]              mr_q  [N_MATCH];
    logic [W-1:0]              cap_q [N_CAP];
    match_act_t [N_MATCH-1:0]  mact_q;
    cap_cfg_t   [N_CAP-1:0]    ccfg_q;
    logic [NFLAG-1:0]          flags_q;
    logic [N_MATCH-1:0]        m_hit, m_clr, m_stop, m_ien;
    logic [N_CAP-1:0]          c_hit, c_ien;
    logic                      cnt_hit, ptick, tick;
    logic                      we_ctrl, we_presc, we_mact, we_ccfg, we_flags;

    assign we_ctrl  = wr_en && int'(wr_addr) == A_CTRL;
    assign we_presc = wr_en && int'(wr_addr) == A_PRESC;
    assign we_mact  = wr_en && int'(wr_addr) == A_MACT;
    assign we_ccfg  = wr_en && int'(wr_addr) == A_CCFG;
    assign we_flags = wr_en && int'(wr_addr) == A_FLAGS;

    // ---------------- count sources ----------------
    tmr_edge_sync #(.SYNC(SYNC)) u_cnt_sync (
        .clk (clk), .rst (rst), .din (cnt_in),
        .sel (ctrl_q.cnt_edge), .hit (cnt_hit)
    );

    tmr_prescaler #(.W(W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctrl_q.hold),
        .en    (ctrl_q.run && !ctrl_q.cnt_mode && !ctrl_q.hold),
        .limit (presc_q),
        .count (pc),
        .tick  (ptick)
    );

    assign tick = ctrl_q.run && !ctrl_q.hold && (ctrl_q.cnt_mode ? cnt_hit : ptick);

    // ---------------- match units ----------------
    for (genvar g = 0; g < N_MATCH; g++) begin : g_match
        assign m_hit[g]  = tick && (tc_q == mr_q[g]);
        assign m_clr[g]  = m_hit[g] && mact_q[g].clr;
        assign m_stop[g] = m_hit[g] && mact_q[g].stop;
        assign m_ien[g]  = mact_q[g].irq_en;

        // R5: a match leaves its flag set and its request high next cycle
        assert_match_flag_R5: assert property (@(posedge clk) disable iff (rst)
            m_hit[g] |=> (flags_q[g] && dma_req[g]));
    end

    // ---------------- capture channels ----------------
    for (genvar c = 0; c < N_CAP; c++) begin : g_cap
        tmr_edge_sync #(.SYNC(SYNC)) u_sync (
            .clk (clk), .rst (rst), .din (cap_in[c]),
            .sel (ccfg_q[c].sel), .hit (c_hit[c])
        );
        tmr_capture #(.W(W)) u_cap (
            .clk (clk), .rst (rst), .hit (c_hit[c]),
            .tc (tc_q), .value (cap_q[c])
        );
        assign c_ien[c] = ccfg_q[c].irq_en;

        // R9: an event wins against a clear of its own flag
        assert_cap_flag_R9: assert property (@(posedge clk) disable iff (rst)
            c_hit[c] |=> flags_q[N_MATCH+c]);
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            mact_q  <= '0;
            ccfg_q  <= '0;
            for (int i = 0; i < N_MATCH; i++) mr_q[i] <= '0;
        end else begin
            if (we_ctrl)       ctrl_q     <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
            else if (|m_stop)  ctrl_q.run <= 1'b0;
            if (we_presc) presc_q <= wr_data;
            if (we_mact)  mact_q  <= wr_data[MACT_W-1:0];
            if (we_ccfg)  ccfg_q  <= wr_data[CCFG_W-1:0];
            for (int i = 0; i < N_MATCH; i++)
                if (wr_en && int'(wr_addr) == A_MR_BASE + i) mr_q[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_q.hold)  tc_q <= '0;
        else if (tick) begin
            if (|m_clr)          tc_q <= '0;
            else if (!(|m_stop)) tc_q <= tc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            dma_req <= '0;
        end else begin
            flags_q <= (flags_q & ~(we_flags ? wr_data[NFLAG-1:0] : '0)) | {c_hit, m_hit};
            dma_req <= m_hit;
        end
    end

    assign irq = |(flags_q & {c_ien, m_ien});

    // ---------------- read mux ----------------
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == A_CTRL)  rd_data = W'(ctrl_q);
        if (int'(rd_addr) == A_PRESC) rd_data = presc_q;
        if (int'(rd_addr) == A_TC)    rd_data = tc_q;
        if (int'(rd_addr) == A_PC)    rd_data = pc;
        if (int'(rd_addr) == A_MACT)  rd_data = W'(mact_q);
        if (int'(rd_addr) == A_CCFG)  rd_data = W'(ccfg_q);
        if (int'(rd_addr) == A_FLAGS) rd_data = W'(flags_q);
        for (int i = 0; i < N_MATCH; i++)
            if (int'(rd_addr) == A_MR_BASE + i) rd_data = mr_q[i];
        for (int j = 0; j < N_CAP; j++)
            if (int'(rd_addr) == A_CAP + j) rd_data = cap_q[j];
    end

    // ---------------- assertions ----------------
    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hold |=> (tc_q == '0 && pc == '0));

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ctrl_q.hold) |=> $stable(tc_q));

    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && |m_clr) |=> tc_q == '0);

    assert_stop_run_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && |m_stop && !we_ctrl) |=> !ctrl_q.run);

    assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && |m_stop && !(|m_clr) && !ctrl_q.hold) |=> tc_q == $past(tc_q));

endmodule

// File: tb/tb_mtc_timer.sv
module tb_mtc_timer;

    localparam logic [3:0] R_CTRL = 4'd0, R_PRESC = 4'd1, R_TC = 4'd2, R_PC = 4'd3;
    localparam logic [3:0] R_MR0 = 4'd4, R_MACT = 4'd8, R_CCFG = 4'd9;
    localparam logic [3:0] R_CAP0 = 4'd10, R_CAP1 = 4'd11, R_FLAGS = 4'd12;

    // prescale, idle cycles, expected count, expected prescale count
    localparam int NVEC = 5;
    localparam int VEC [NVEC][4] = '{
        '{0,  8, 10, 0},
        '{2, 10,  4, 0},
        '{3,  9,  2, 3},
        '{6, 20,  3, 1},
        '{1,  0,  1, 0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        cnt_in;
    logic [1:0]  cap_in;
    logic        irq;
    logic [3:0]  dma_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mtc_timer dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .cnt_in (cnt_in), .cap_in (cap_in), .irq (irq), .dma_req (dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cnt();
        @(negedge clk); cnt_in = 1'b1;
        idle(3);        cnt_in = 1'b0;
        idle(3);
    endtask

    initial begin
        logic [31:0] v;
        int          maxtc;
        int          pulses;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; cnt_in = 1'b0; cap_in = '0;
        idle(3);
        rst = 1'b0;

        // R1: reset state
        rd(R_CTRL, v);  chk("R1 ctrl", v, 32'h0);
        rd(R_TC, v);    chk("R1 count", v, 32'h0);
        rd(R_PC, v);    chk("R1 prescale count", v, 32'h0);
        rd(R_MR0, v);   chk("R1 compare0", v, 32'h0);
        rd(R_CAP0, v);  chk("R1 capture0", v, 32'h0);
        rd(R_FLAGS, v); chk("R1 flags", v, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 dma", {28'h0, dma_req}, 32'h0);

        // R2: prescaler vectors
        for (int k = 0; k < NVEC; k++) begin
            wr(R_CTRL, 32'h10);
            wr(R_PRESC, VEC[k][0]);
            wr(R_CTRL, 32'h1);
            idle(VEC[k][1]);
            wr(R_CTRL, 32'h0);
            rd(R_TC, v); chk($sformatf("R2 vec%0d count", k), v, VEC[k][2]);
            rd(R_PC, v); chk($sformatf("R2 vec%0d prescale count", k), v, VEC[k][3]);
        end
        rd(R_PRESC, v); chk("R11 prescale readback", v, 32'h1);

        // R3: hold clears both counts (count is 1 from last vector, prescale 6 earlier)
        wr(R_PRESC, 32'h5);
        wr(R_CTRL, 32'h1);
        idle(3);
        wr(R_CTRL, 32'h10);
        rd(R_TC, v); chk("R3 hold count", v, 32'h0);
        rd(R_PC, v); chk("R3 hold prescale count", v, 32'h0);
        wr(R_PRESC, 32'h0);

        // R11: compare registers and flag clear
        for (int m = 1; m < 4; m++) wr(R_MR0 + 4'(m), 32'hFFFF_FFFF);
        rd(R_MR0 + 4'd3, v); chk("R11 compare3 readback", v, 32'hFFFF_FFFF);
        wr(R_FLAGS, 32'h3F);
        rd(R_FLAGS, v); chk("R9 flags cleared", v, 32'h0);

        // R5/R6: restart on match 0 at 4
        wr(R_MR0, 32'd4);
        wr(R_MACT, 32'h3);
        wr(R_CTRL, 32'h10);
        wr(R_CTRL, 32'h1);
        rd_addr = R_TC;
        maxtc = 0; pulses = 0;
        for (int t = 0; t < 30; t++) begin
            @(negedge clk); #1;
            if (int'(rd_data) > maxtc) maxtc = int'(rd_data);
            if (dma_req[0]) pulses++;
        end
        chk("R6 count ceiling", maxtc, 32'd4);
        chk("R5 dma pulses", pulses, 32'd6);
        wr(R_CTRL, 32'h0);
        rd(R_FLAGS, v); chk("R5 match flag", v, 32'h1);
        chk("R10 irq enabled match", {31'h0, irq}, 32'h1);
        wr(R_FLAGS, 32'h1);
        rd(R_FLAGS, v); chk("R9 write-one clear", v, 32'h0);
        chk("R10 irq after clear", {31'h0, irq}, 32'h0);

        // R7: stop only at 7
        wr(R_MR0, 32'd7);
        wr(R_MACT, 32'h4);
        wr(R_CTRL, 32'h10);
        wr(R_CTRL, 32'h1);
        idle(20);
        rd(R_TC, v);    chk("R7 stop count", v, 32'd7);
        rd(R_CTRL, v);  chk("R7 run cleared", v, 32'h0);
        rd(R_FLAGS, v); chk("R5 stop flag", v, 32'h1);
        chk("R10 irq disabled source", {31'h0, irq}, 32'h0);

        // R8: captures with count frozen at 7; cap0 rising+irq, cap1 falling
        wr(R_CCFG, 32'h15);
        wr(R_FLAGS, 32'h3F);
        @(negedge clk); cap_in[0] = 1'b1;
        idle(5);
        rd(R_CAP0, v);  chk("R8 capture0 rising", v, 32'd7);
        rd(R_FLAGS, v); chk("R8 capture0 flag", v, 32'h10);
        chk("R10 irq capture", {31'h0, irq}, 32'h1);
        cap_in[0] = 1'b0;
        cap_in[1] = 1'b1;
        idle(5);
        rd(R_CAP1, v);  chk("R8 capture1 rising ignored", v, 32'h0);
        rd(R_FLAGS, v); chk("R8 capture1 flag untouched", v, 32'h10);
        cap_in[1] = 1'b0;
        idle(5);
        rd(R_CAP1, v);  chk("R8 capture1 falling", v, 32'd7);
        wr(R_FLAGS, 32'h10);
        rd(R_FLAGS, v); chk("R8 capture1 flag", v, 32'h20);
        chk("R10 irq capture1 disabled", {31'h0, irq}, 32'h0);

        // R9: clear lands on the same edge as capture0 sets its flag
        @(negedge clk); cap_in[0] = 1'b1;
        @(negedge clk);
        wr(R_FLAGS, 32'h10);
        rd(R_FLAGS, v); chk("R9 set beats clear", v & 32'h10, 32'h10);
        wr(R_FLAGS, 32'h10);
        rd(R_FLAGS, v); chk("R9 later clear", v & 32'h10, 32'h0);
        cap_in[0] = 1'b0;

        // R7: reset and stop together at 5
        wr(R_MR0, 32'd5);
        wr(R_MACT, 32'h6);
        wr(R_CTRL, 32'h10);
        wr(R_CTRL, 32'h1);
        idle(20);
        rd(R_TC, v);   chk("R7 reset+stop count", v, 32'h0);
        rd(R_CTRL, v); chk("R7 reset+stop run", v, 32'h0);

        // R4: counter mode, rising then both edges; prescaler bypassed
        wr(R_MACT, 32'h0);
        wr(R_PRESC, 32'h5);
        wr(R_CTRL, 32'h16);
        wr(R_CTRL, 32'h07);
        for (int p = 0; p < 6; p++) pulse_cnt();
        idle(4);
        rd(R_TC, v); chk("R4 rising edges", v, 32'd6);
        rd(R_PC, v); chk("R4 prescale idle", v, 32'h0);
        wr(R_CTRL, 32'h1E);
        wr(R_CTRL, 32'h0F);
        for (int p = 0; p < 3; p++) pulse_cnt();
        idle(4);
        rd(R_TC, v); chk("R4 both edges", v, 32'd6);
        wr(R_CTRL, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule